// File: doc/BRIEF.md
# Interrupt Status Aggregation Unit

This unit gathers interrupt events from two sources, a storage-bus side and a DMA engine, into sticky detail registers. A three-bit summary register condenses them: a software-clearable on-the-fly flag, a bus-pending bit and a DMA-pending bit. An active-low interrupt request pin is asserted while any summary bit is set. Software can take the interrupt, or it can poll the summary register instead.

The two pending bits are cleared as a side effect of reading their detail registers. A read returns the held event bits and clears them. The bus side has two detail registers, and its pending bit falls only after both have been read. The on-the-fly flag is cleared by writing a one to its bit position. Each detail register has a per-bit enable. The enable decides whether a held bit counts toward its pending flag, but the bit is captured either way.

Register map (`reg_addr_i`):

| Address | Register |
|---|---|
| 0 | summary |
| 1 | bus detail 0 |
| 2 | bus detail 1 |
| 3 | DMA detail |
| 4 | bus enable 0 |
| 5 | bus enable 1 |
| 6 | DMA enable |
| 7 | unmapped, reads zero |

Top module: `intr_status_agg`

## Requirements
- R1: After reset, every detail register reads 0 and the summary reads 0. Every enable register reads all ones, and `irq_n_o` is 1.
- R2: An event input bit set for one cycle sets the matching detail bit from the next cycle. The bit then stays set until that detail register is read.
- R3: A read of a detail register (address 1, 2 or 3) returns its held bits on `reg_rdata_o` in the same cycle, zero-extended. It clears those bits from the next cycle.
- R4: An event bit that arrives in the same cycle as a clearing read of its register is still set after the read.
- R5: Summary bit 1 is the OR of the enabled bits of both bus detail registers. When both hold bits, reading only one of them leaves bit 1 set.
- R6: Summary bit 0 is the OR of the enabled bits of the DMA detail register.
- R7: Summary bit 2 is set by `otf_evt_i` and cleared by a write to address 0 with data bit 2 equal to 1. A write with bit 2 equal to 0 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R8: The enable registers (addresses 4, 5 and 6) are written and read back through the register port. A cleared enable bit keeps its detail bit out of the summary, but the detail bit is still captured.
- R9: `irq_n_o` goes to 0 one cycle after any summary bit becomes set. It returns to 1 one cycle after the last summary bit clears.
- R10: Writes to the detail registers and to summary bits 0 and 1 have no effect.
- R11: Reads of the summary, enable and unmapped addresses change no state. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_evt0_i | input | BUS_W | Event pulses for bus detail register 0 |
| bus_evt1_i | input | BUS_W | Event pulses for bus detail register 1 |
| dma_evt_i | input | DMA_W | Event pulses for the DMA detail register |
| otf_evt_i | input | 1 | Sets the on-the-fly flag |
| reg_addr_i | input | ADDR_W | Register address |
| reg_rd_i | input | 1 | Read strobe; clears a detail register at the clock edge |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_n_o | output | 1 | Registered active-low interrupt request |

## Verification
The assertions check four things on every cycle. A held bit survives every cycle without a clearing read, and an event is never lost to a read in the same cycle. A clearing read empties the bits it returned. The write-one-to-clear flag and the request pin follow their summary terms one cycle later. Some behaviour can only be shown by the bench's scenarios, checked against a reference model: the two-read rule for the bus pending bit, masking by the enables, the rule that writes to read-only registers do nothing, and the read-back values under random traffic.

// File: rtl/isr_pkg.sv
package isr_pkg;
   // register addresses
   localparam int unsigned ADR_SUM  = 0;
   localparam int unsigned ADR_BUS0 = 1;
   localparam int unsigned ADR_BUS1 = 2;
   localparam int unsigned ADR_DMA  = 3;
   localparam int unsigned ADR_EN0  = 4;
   localparam int unsigned ADR_EN1  = 5;
   localparam int unsigned ADR_END  = 6;
   localparam int unsigned MIN_ADDR_W = 3;

   // summary bit positions
   localparam int unsigned SUM_DMA = 0;
   localparam int unsigned SUM_BUS = 1;
   localparam int unsigned SUM_OTF = 2;
   localparam int unsigned SUM_W   = 3;

   localparam int unsigned NUM_BUS_REGS = 2;
endpackage

// File: rtl/isr_sticky_reg.sv
module isr_sticky_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_mask_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] nxt;

   // a set in the same cycle as a clear wins
   always_comb nxt = (q_o & ~clr_mask_i) | set_i;

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= nxt;
   end

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_o & ($past(q_o) & ~$past(clr_mask_i))) == ($past(q_o) & ~$past(clr_mask_i))));
   // R4
   set_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
   // R3
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_mask_i) |=> ((q_o & $past(clr_mask_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/isr_cfg_reg.sv
module isr_cfg_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q_o <= RST_VAL;
      else if (we_i) q_o <= d_i;
   end
endmodule

// File: rtl/isr_irq_drv.sv
module isr_irq_drv (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_i,
   output logic irq_n_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq_n_o <= 1'b1;
      else        irq_n_o <= ~pend_i;
   end
endmodule

// File: rtl/intr_status_agg.sv
module intr_status_agg
   import isr_pkg::*;
#(
   parameter int unsigned BUS_W  = 8,
   parameter int unsigned DMA_W  = 6,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  bus_evt0_i,
   input  logic [BUS_W-1:0]  bus_evt1_i,
   input  logic [DMA_W-1:0]  dma_evt_i,
   input  logic              otf_evt_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_rd_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_n_o
);
   localparam int unsigned WIDEST = (BUS_W > DMA_W) ? BUS_W : DMA_W;

   // elaboration-time parameter checks
   if (BUS_W < 1 || DMA_W < 1) begin : g_bad_w
      $error("detail widths must be at least one bit");
   end
   if (WIDEST > DATA_W || DATA_W < SUM_W) begin : g_bad_data
      $error("DATA_W too narrow for the registers it carries");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [BUS_W-1:0] bus_evt [NUM_BUS_REGS];
   logic [BUS_W-1:0] bus_q   [NUM_BUS_REGS];
   logic [BUS_W-1:0] bus_en  [NUM_BUS_REGS];
   logic [NUM_BUS_REGS-1:0] bus_any;
   logic [DMA_W-1:0] dma_q, dma_en;
   logic otf_q, bus_pend, dma_pend, any_pend;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
      return a == ADDR_W'(r);
   endfunction

   assign bus_evt[0] = bus_evt0_i;
   assign bus_evt[1] = bus_evt1_i;

   // bus detail and enable registers
   for (genvar i = 0; i < NUM_BUS_REGS; i++) begin : g_bus
      logic rd_hit, wr_en;
      assign rd_hit = reg_rd_i && hit(reg_addr_i, ADR_BUS0 + i);
      assign wr_en  = reg_wr_i && hit(reg_addr_i, ADR_EN0 + i);

      isr_sticky_reg #(.W(BUS_W)) u_det (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_i     (bus_evt[i]),
         .clr_mask_i({BUS_W{rd_hit}}),
         .q_o       (bus_q[i])
      );
      isr_cfg_reg #(.W(BUS_W), .RST_VAL({BUS_W{1'b1}})) u_en (
         .clk  (clk),
         .rst_n(rst_n),
         .we_i (wr_en),
         .d_i  (reg_wdata_i[BUS_W-1:0]),
         .q_o  (bus_en[i])
      );
      assign bus_any[i] = |(bus_q[i] & bus_en[i]);
   end

   // DMA detail and enable
   logic dma_rd_hit;
   assign dma_rd_hit = reg_rd_i && hit(reg_addr_i, ADR_DMA);

   isr_sticky_reg #(.W(DMA_W)) u_dma_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (dma_evt_i),
      .clr_mask_i({DMA_W{dma_rd_hit}}),
      .q_o       (dma_q)
   );
   isr_cfg_reg #(.W(DMA_W), .RST_VAL({DMA_W{1'b1}})) u_dma_en (
      .clk  (clk),
      .rst_n(rst_n),
      .we_i (reg_wr_i && hit(reg_addr_i, ADR_END)),
      .d_i  (reg_wdata_i[DMA_W-1:0]),
      .q_o  (dma_en)
   );

   // on-the-fly flag, write-one-to-clear
   logic otf_clr;
   assign otf_clr = reg_wr_i && hit(reg_addr_i, ADR_SUM) && reg_wdata_i[SUM_OTF];

   isr_sticky_reg #(.W(1)) u_otf (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (otf_evt_i),
      .clr_mask_i(otf_clr),
      .q_o       (otf_q)
   );

   assign bus_pend = |bus_any;
   assign dma_pend = |(dma_q & dma_en);
   assign any_pend = otf_q | bus_pend | dma_pend;

   isr_irq_drv u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (any_pend),
      .irq_n_o(irq_n_o)
   );

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_W'(ADR_SUM): begin
            reg_rdata_o[SUM_DMA] = dma_pend;
            reg_rdata_o[SUM_BUS] = bus_pend;
            reg_rdata_o[SUM_OTF] = otf_q;
         end
         ADDR_W'(ADR_BUS0): reg_rdata_o[BUS_W-1:0] = bus_q[0];
         ADDR_W'(ADR_BUS1): reg_rdata_o[BUS_W-1:0] = bus_q[1];
         ADDR_W'(ADR_DMA):  reg_rdata_o[DMA_W-1:0] = dma_q;
         ADDR_W'(ADR_EN0):  reg_rdata_o[BUS_W-1:0] = bus_en[0];
         ADDR_W'(ADR_EN1):  reg_rdata_o[BUS_W-1:0] = bus_en[1];
         ADDR_W'(ADR_END):  reg_rdata_o[DMA_W-1:0] = dma_en;
         default:           reg_rdata_o = '0;
      endcase
   end

   // R7
   otf_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (otf_clr && !otf_evt_i) |=> !otf_q);
   // R7
   otf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      otf_evt_i |=> otf_q);
   // R9
   irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (otf_q || bus_pend || dma_pend) |=> !irq_n_o);
   // R9
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(otf_q || bus_pend || dma_pend) |=> irq_n_o);
endmodule

// File: tb/tb_intr_status_agg.sv
module tb_intr_status_agg;
   localparam int CLK_PERIOD = 10;
   localparam int BW = 8;
   localparam int DW = 6;

   logic clk = 0, rst_n = 0;
   logic [BW-1:0] ev0 = '0, ev1 = '0;
   logic [DW-1:0] evd = '0;
   logic otf = 0, rd = 0, wr = 0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic irq_n;

   int n_run = 0, n_fail = 0;

   // reference model state
   logic [BW-1:0] m0 = '0, m1 = '0, e0 = '1, e1 = '1;
   logic [DW-1:0] md = '0, ed = '1;
   logic mo = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intr_status_agg dut (
      .clk(clk), .rst_n(rst_n), .bus_evt0_i(ev0), .bus_evt1_i(ev1),
      .dma_evt_i(evd), .otf_evt_i(otf), .reg_addr_i(addr), .reg_rd_i(rd),
      .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_n_o(irq_n)
   );

   function automatic logic m_pend();
      return mo | (|(m0 & e0)) | (|(m1 & e1)) | (|(md & ed));
   endfunction

   function automatic logic [7:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {5'd0, mo, (|(m0 & e0)) | (|(m1 & e1)), |(md & ed)};
         3'd1: return m0;
         3'd2: return m1;
         3'd3: return {2'd0, md};
         3'd4: return e0;
         3'd5: return e1;
         3'd6: return {2'd0, ed};
         default: return 8'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0: return "R5";
         3'd1, 3'd2, 3'd3: return "R3";
         3'd7: return "R11";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock of stimulus; checks read data before the edge, irq after it
   task automatic step(input logic [BW-1:0] a0, input logic [BW-1:0] a1, input logic [DW-1:0] ad,
                       input logic os, input logic r, input logic w, input logic [2:0] ad_r,
                       input logic [7:0] wd, input string tag);
      logic irq_e;
      @(negedge clk);
      ev0 = a0; ev1 = a1; evd = ad; otf = os; rd = r; wr = w; addr = ad_r; wdata = wd;
      #1;
      if (r) chk(rdata == m_read(ad_r), tag, rdata, m_read(ad_r));
      @(posedge clk);
      irq_e = ~m_pend();
      if (r && ad_r == 3'd1) m0 = a0; else m0 = m0 | a0;
      if (r && ad_r == 3'd2) m1 = a1; else m1 = m1 | a1;
      if (r && ad_r == 3'd3) md = ad; else md = md | ad;
      if (w && ad_r == 3'd0 && wd[2]) mo = 1'b0;
      if (os) mo = 1'b1;
      if (w && ad_r == 3'd4) e0 = wd;
      if (w && ad_r == 3'd5) e1 = wd;
      if (w && ad_r == 3'd6) ed = wd[DW-1:0];
      #1;
      chk(irq_n == irq_e, "R9", irq_n, irq_e);
   endtask

   task automatic idle_rd(input logic [2:0] a, input string tag);
      step('0, '0, '0, 0, 1, 0, a, 8'd0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed1d));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: reset state of every address and the pin
      chk(irq_n == 1'b1, "R1", irq_n, 1);
      for (int a = 0; a < 8; a++) idle_rd(3'(a), "R1");

      // R2: sticky capture, held through idle cycles
      step(8'h10, '0, '0, 0, 0, 0, 3'd7, 0, "R2");
      repeat (3) step('0, '0, '0, 0, 0, 0, 3'd0, 0, "R2");
      idle_rd(3'd1, "R2");
      idle_rd(3'd1, "R3");

      // R4: event in the same cycle as the clearing read
      step(8'h08, '0, '0, 0, 0, 0, 3'd0, 0, "R4");
      step(8'h04, '0, '0, 0, 1, 0, 3'd1, 0, "R4");
      chk(m0 == 8'h04, "R4", m0, 8'h04);
      idle_rd(3'd1, "R4");

      // R5: both bus registers must be read
      step(8'h01, 8'h02, '0, 0, 0, 0, 3'd0, 0, "R5");
      idle_rd(3'd1, "R5");
      idle_rd(3'd0, "R5");
      idle_rd(3'd2, "R5");
      idle_rd(3'd0, "R5");

      // R6: DMA pending and its clear
      step('0, '0, 6'h20, 0, 0, 0, 3'd0, 0, "R6");
      idle_rd(3'd0, "R6");
      idle_rd(3'd3, "R6");
      idle_rd(3'd0, "R6");

      // R7: set, write-zero no effect, write-one clear, set beats clear
      step('0, '0, '0, 1, 0, 0, 3'd0, 0, "R7");
      step('0, '0, '0, 0, 0, 1, 3'd0, 8'hFB, "R7");
      idle_rd(3'd0, "R7");
      step('0, '0, '0, 1, 0, 1, 3'd0, 8'h04, "R7");
      idle_rd(3'd0, "R7");
      step('0, '0, '0, 0, 0, 1, 3'd0, 8'h04, "R7");
      idle_rd(3'd0, "R7");

      // R8: masked bit captured but not summarised
      step('0, '0, '0, 0, 0, 1, 3'd4, 8'hFE, "R8");
      idle_rd(3'd4, "R8");
      step(8'h01, '0, '0, 0, 0, 0, 3'd0, 0, "R8");
      idle_rd(3'd0, "R8");
      idle_rd(3'd1, "R8");
      step('0, '0, '0, 0, 0, 1, 3'd4, 8'hFF, "R8");

      // R10: writes to detail and to read-only summary bits ignored
      step('0, '0, 6'h03, 0, 0, 0, 3'd0, 0, "R10");
      step('0, '0, '0, 0, 0, 1, 3'd3, 8'h00, "R10");
      step('0, '0, '0, 0, 0, 1, 3'd0, 8'h03, "R10");
      idle_rd(3'd0, "R10");
      idle_rd(3'd3, "R10");

      // R11: non-clearing reads leave state alone
      step(8'h80, '0, '0, 0, 0, 0, 3'd0, 0, "R11");
      idle_rd(3'd7, "R11");
      idle_rd(3'd0, "R11");
      idle_rd(3'd5, "R11");
      idle_rd(3'd1, "R11");

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] a;
         a = 3'($urandom % 8);
         step(($urandom % 4 == 0) ? BW'(1 << ($urandom % BW)) : '0,
              ($urandom % 5 == 0) ? BW'(1 << ($urandom % BW)) : '0,
              ($urandom % 5 == 0) ? DW'(1 << ($urandom % DW)) : '0,
              ($urandom % 16 == 0),
              ($urandom % 2 == 0),
              ($urandom % 6 == 0),
              a, 8'($urandom), tag_of(a));
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule